// File: doc/BRIEF.md
# Bitstream Low-Pass Current Filter

This block turns the single-bit output of a delta-sigma modulator into a signed multi-bit current sample. It runs on the modulator clock. Each incoming bit is first mapped to a positive or negative full-scale value. That value then passes through four identical first-order recursive low-pass sections. The shared time constant of those sections is set by a 4-bit shift value.

A small shift gives a fast, lightly filtered sample. A large shift gives a slow one. The filter therefore doubles as a tunable first-order-like delay in a current feedback loop. To suppress converter ripple, the corner of the filter is usually placed below twice the switching frequency.

The filtered value is rounded and registered every N modulator clocks. A one-cycle valid strobe marks each new sample.

Top module: `sd_iir_filter`

## Requirements
- R1: While `rst_ni` is low, `sample_o` is 0 and `valid_o` is 0. Releasing reset starts all four section states from zero.
- R2: Input bit 1 is taken as +FS and bit 0 as -FS, where FS = 2^(OUT_W-1)-1 (32767 by default). A constant stream of either value settles to exactly +FS or -FS at `sample_o`.
- R3: On each clock, each section updates its state y to y + ((x - y) >>> k), where k = `shift_i` and the shift is arithmetic. With k = 0 and a strobe every clock, a change on `bit_i` reaches `sample_o` exactly 5 clock edges after it is applied: 4 sections plus the output register.
- R4: For a periodic bitstream with a fraction d of ones, the settled sample equals FS*(2d-1) within the ripple tolerance that the chosen k allows.
- R5: `valid_o` is high for one clock in every N clocks, where N = `dec_i`. An N of 0 or 1 gives a strobe on every clock.
- R6: `sample_o` changes only in the clock where `valid_o` rises or stays high. Between strobes it holds its value.
- R7: The section states never leave the range ±FS (in internal scaling). Once the input is constant, the output is constant, with no limit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Modulator bitstream |
| shift_i | input | 4 | Section time-constant shift k |
| dec_i | input | DEC_W | Output strobe period N |
| sample_o | output | OUT_W | Rounded, signed filtered sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The bench drives constant streams at a slow shift and expects exactly ±32767. A design that floors instead of rounding, or that lets truncation error pile up across the sections, settles one or more codes short. With k = 0 it checks the exact five-edge latency; a missing or extra register shows up as an off-by-one cycle. It also checks the strobe period, including N = 0 and a period change, and checks that the sample holds between strobes. Finally, it resets the filter in the middle of a run and then uses the slowest shift, so that a state left uncleared by reset shows up as a non-zero output.

// File: rtl/sd_iir_pkg.sv
package sd_iir_pkg;
  localparam int SHIFT_W = 4;
  typedef logic [SHIFT_W-1:0] shift_t;

  function automatic longint full_scale(input int width);
    return (longint'(1) << (width - 1)) - 1;
  endfunction
endpackage

// File: rtl/sd_iir_stage.sv
module sd_iir_stage
  import sd_iir_pkg::*;
#(
  parameter int ACC_W = 35,
  parameter logic signed [ACC_W-1:0] LIM = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  shift_t                  shift_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] y_q;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W-1:0] step;

  // one guard bit for the difference; step magnitude never exceeds it
  assign diff = {x_i[ACC_W-1], x_i} - {y_q[ACC_W-1], y_q};
  assign step = ACC_W'(diff >>> shift_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_q + step;
  end

  assign y_o = y_q;

  a_r3_k0_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i == '0) |=> (y_q == $past(x_i)));

  a_r7_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_q <= LIM) && (y_q >= -LIM));
endmodule

// File: rtl/sd_iir_strobe.sv
module sd_iir_strobe #(
  parameter int DEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEC_W-1:0] dec_i,
  output logic             fire_o
);
  logic [DEC_W-1:0] cnt_q;
  logic [DEC_W:0]   cnt_inc;

  assign cnt_inc = (DEC_W+1)'(cnt_q) + (DEC_W+1)'(1);
  // >= also covers a period shortened below the current count
  assign fire_o  = cnt_inc >= {1'b0, dec_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DEC_W'(1);
  end
endmodule

// File: rtl/sd_iir_filter.sv
module sd_iir_filter
  import sd_iir_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int FRAC_W   = 18,
  parameter int N_STAGES = 4,
  parameter int DEC_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic [DEC_W-1:0]        dec_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam int ACC_W = OUT_W + FRAC_W + 1;
  localparam longint FS = full_scale(OUT_W);
  localparam logic signed [ACC_W-1:0] FS_ACC   = ACC_W'(FS <<< FRAC_W);
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(longint'(1) <<< (FRAC_W - 1));

  logic signed [ACC_W-1:0] chain [N_STAGES+1];
  logic signed [ACC_W-1:0] rnd;
  logic signed [OUT_W-1:0] sample_d;
  logic                    fire;

  assign chain[0] = bit_i ? FS_ACC : -FS_ACC;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    sd_iir_stage #(
      .ACC_W (ACC_W),
      .LIM   (FS_ACC)
    ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (shift_i),
      .x_i     (chain[g]),
      .y_o     (chain[g+1])
    );
  end

  sd_iir_strobe #(.DEC_W(DEC_W)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec_i),
    .fire_o (fire)
  );

  assign rnd      = chain[N_STAGES] + RND_HALF;
  assign sample_d = OUT_W'(rnd >>> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) sample_o <= sample_d;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (sample_o == '0 && !valid_o);
  end

  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dec_i > DEC_W'(1)) |=> (!valid_o || !$stable(dec_i)));

  a_r6_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));

  a_r7_out_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o <= OUT_W'(FS)) && (sample_o >= -OUT_W'(FS)));
endmodule

// File: tb/sd_iir_filter_tb.sv
module sd_iir_filter_tb;
  localparam int FS = 32767;
  localparam int NV = 6;
  localparam logic [3:0] PAT [NV] = '{4'b1111, 4'b0000, 4'b1010, 4'b0111, 4'b0001, 4'b0011};
  localparam int         KSH [NV] = '{8, 6, 3, 4, 5, 8};
  localparam int         EXP [NV] = '{FS, -FS, 0, 16384, -16384, 0};
  localparam int         TOL [NV] = '{0, 0, 100, 200, 200, 50};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic [3:0]  shift = 4'd0;
  logic [7:0]  dec = 8'd1;
  logic signed [15:0] sample;
  logic        valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_iir_filter u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bit_i    (bit_in),
    .shift_i  (shift),
    .dec_i    (dec),
    .sample_o (sample),
    .valid_o  (valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [3:0] pat, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      bit_in = pat[i % 4];
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (valid) return;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first;
    int diffv;
    int cnt;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check(sample == 0 && !valid, "R1 reset", sample, 0);
    rst_n = 1'b1;

    // R2 R4 R7: settled levels for several duty cycles
    for (int v = 0; v < NV; v++) begin
      shift = 4'(KSH[v]);
      drive(PAT[v], 8000);
      for (int s = 0; s < 4; s++) begin
        drive(PAT[v], 1);
        diffv = int'(sample) - EXP[v];
        if (diffv < 0) diffv = -diffv;
        check(diffv <= TOL[v], (TOL[v] == 0) ? "R2/R7 exact level" : "R4 duty mean",
              sample, EXP[v]);
      end
    end

    // R3: pass-through latency with k = 0
    shift = 4'd0;
    dec = 8'd1;
    drive(4'b0000, 10);
    check(sample == -FS, "R3 pre-step", sample, -FS);
    @(negedge clk);
    bit_in = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      check(sample == -FS, "R3 before edge 5", sample, -FS);
    end
    @(negedge clk);
    check(sample == FS, "R3 at edge 5", sample, FS);

    // R5: strobe every 5 clocks
    dec = 8'd5;
    wait_valid();
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      check(valid == ((c % 5) == 0), "R5 period 5", int'(valid), int'((c % 5) == 0));
    end
    // R5: N = 0 strobes every clock
    dec = 8'd0;
    @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (valid) cnt++;
    end
    check(cnt == 10, "R5 period 0", cnt, 10);

    // R6: hold between strobes while the input toggles
    shift = 4'd0;
    dec = 8'd200;
    wait_valid();
    first = sample;
    drive(4'b0101, 100);
    check(sample == first && !valid, "R6 hold", sample, first);
    wait_valid();
    drive(4'b0000, 1);
    check(valid == 1'b0, "R6 strobe single", int'(valid), 0);

    // R1: mid-run reset clears section states
    shift = 4'd0;
    dec = 8'd1;
    drive(4'b1111, 20);
    check(sample == FS, "R1 pre-reset level", sample, FS);
    rst_n = 1'b0;
    @(negedge clk);
    check(sample == 0 && !valid, "R1 mid reset", sample, 0);
    shift = 4'd15;
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b1111, 50);
    check(sample >= 0 && sample <= 1, "R1 states cleared", sample, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule